// File: doc/BRIEF.md
# Signed-Digit Constant Multiplier

This block multiplies an unsigned operand by a constant fixed when the design is elaborated. At elaboration the constant is recoded into a non-adjacent signed-digit form with digits −1, 0 and +1, in which no two neighbouring digits are both nonzero. Only the nonzero digits become hardware. Each one becomes a shifted copy of the operand, negated for a −1 digit. These terms are summed in a pairwise adder tree with a register at every level.

Because the recoding leaves roughly a third of the digit positions nonzero, fewer terms are needed than with a plain binary shift-and-add. The tree is also shallower. A typical use is the fixed-factor multiplication needed when moving field elements into or out of Montgomery form. That reduction step lies outside the block.

Operands enter and products leave through valid/ready streams.
- An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A product is handed over on a rising edge where `out_valid` and `out_ready` are both high.
- Back-pressure halts the whole pipeline in place. `in_ready` drops in the same cycle in which a presented product is refused.
- Nothing is lost or reordered.

Top module: `naf_const_mult`

## Requirements
- R1: Every product handed over equals the operand of the matching input beat times the constant, exactly, over the full `W+CW` bit width. This holds for the operands 0, 1, all ones and arbitrary values.
- R2: Let `nz` be the number of nonzero digits in the constant's non-adjacent form, and let `LAT = ceil(log2(max(nz,1))) + 1`. While `out_ready` stays high, a beat accepted on rising edge A is presented on `out_valid`/`out_prod` from rising edge A+LAT−1 onward.
- R3: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` keeps its value on the next edge.
- R5: While `rst_n` is low and on the first cycle after it rises, `out_valid` is low and `in_ready` is high.
- R6: Products leave in the order their operands arrived, one per accepted beat. Cycles with `in_valid` low create no product, and at most LAT beats are held inside at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid state |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | W | Unsigned operand |
| out_valid | output | 1 | Product beat offered |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | W+CW | Unsigned product |

## Verification
The bench derives the latency on its own from the count of nonzero signed digits. It obtains that count from the bits that differ between three times the constant and the constant. While the consumer never stalls, each product must appear on the sampling half-cycle that follows edge A+LAT−1 of its accepting edge A, and the bench checks exactly that cycle.

All inputs change just after a rising edge, and all outputs are sampled on the falling edge. The handshake a sample predicts is therefore the one taken at the next rising edge. A second phase randomises `out_ready` and drops the latency check. In that phase it checks order and values, the ready rule and the holding of a refused product from one sample to the next.

// File: rtl/ncm_pkg.sv
package ncm_pkg;
  localparam int KMAX = 64;
  typedef logic [KMAX-1:0] const_t;
  typedef logic [KMAX:0]   digit_mask_t;
  typedef logic [KMAX+1:0] naf_acc_t;

  // Signed-digit recoding: returns the +1 positions or the -1 positions.
  function automatic digit_mask_t naf_mask(const_t k, bit want_neg);
    naf_acc_t    r;
    digit_mask_t m;
    r = naf_acc_t'(k);
    m = '0;
    for (int i = 0; i <= KMAX; i++) begin
      if (r[0]) begin
        if (r[1]) begin
          m[i] = want_neg;
          r = r + naf_acc_t'(1);
        end else begin
          m[i] = !want_neg;
          r = r - naf_acc_t'(1);
        end
      end
      r = r >> 1;
    end
    return m;
  endfunction

  function automatic int term_count(digit_mask_t m);
    int n;
    n = 0;
    for (int i = 0; i <= KMAX; i++) if (m[i]) n++;
    return n;
  endfunction

  // Bit position of the j-th set bit of m.
  function automatic int term_pos(digit_mask_t m, int j);
    int n;
    int p;
    n = 0;
    p = 0;
    for (int i = 0; i <= KMAX; i++) begin
      if (m[i]) begin
        if (n == j) p = i;
        n++;
      end
    end
    return p;
  endfunction

  function automatic int lvl_nodes(int n, int l);
    return (n + (1 << l) - 1) >> l;
  endfunction

  function automatic int lvl_base(int n, int l);
    int b;
    b = 0;
    for (int k = 0; k < l; k++) b += lvl_nodes(n, k);
    return b;
  endfunction
endpackage

// File: rtl/ncm_term.sv
module ncm_term #(
  parameter int W     = 16,
  parameter int PW    = 48,
  parameter int SHIFT = 0,
  parameter int SIGN  = 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic [W-1:0]  din,
  output logic [PW-1:0] term
);
  generate
    if (SIGN > 0) begin : g_pos
      always_ff @(posedge clk) if (en) term <= PW'(din) << SHIFT;
    end else if (SIGN < 0) begin : g_neg
      always_ff @(posedge clk) if (en) term <= '0 - (PW'(din) << SHIFT);
    end else begin : g_zero
      always_ff @(posedge clk) if (en) term <= '0;
    end
  endgenerate
endmodule

// File: rtl/ncm_add.sv
module ncm_add #(
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          en,
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  output logic [PW-1:0] sum
);
  always_ff @(posedge clk) if (en) sum <= a + b;
endmodule

// File: rtl/ncm_valid_pipe.sv
module ncm_valid_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] v;
  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= '0;
        else if (en) v <= vin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) v <= '0;
        else if (en) v <= {v[DEPTH-2:0], vin};
    end
  endgenerate
  assign vout = v[DEPTH-1];
endmodule

// File: rtl/naf_const_mult.sv
module naf_const_mult
  import ncm_pkg::*;
#(
  parameter int          W  = 16,
  parameter int          CW = 32,
  parameter logic [CW-1:0] K = 32'hE3A7_7B5D,
  localparam int         PW = W + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_prod
);
  localparam digit_mask_t PLUS  = naf_mask(const_t'(K), 1'b0);
  localparam digit_mask_t MINUS = naf_mask(const_t'(K), 1'b1);
  localparam digit_mask_t NZM   = PLUS | MINUS;
  localparam int NZ  = term_count(NZM);
  localparam int NL  = (NZ < 1) ? 1 : NZ;
  localparam int D   = (NL <= 1) ? 0 : $clog2(NL);
  localparam int LAT = D + 1;
  localparam int TOT = lvl_base(NL, D + 1);

  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  logic [PW-1:0] nd [TOT];

  generate
    for (genvar j = 0; j < NL; j++) begin : g_leaf
      localparam int P = term_pos(NZM, j);
      localparam int S = (NZ == 0) ? 0 : (PLUS[P] ? 1 : -1);
      ncm_term #(.W(W), .PW(PW), .SHIFT(P), .SIGN(S)) u_term (
        .clk(clk), .en(advance), .din(in_data), .term(nd[j])
      );
    end

    for (genvar l = 1; l <= D; l++) begin : g_lvl
      for (genvar i = 0; i < lvl_nodes(NL, l); i++) begin : g_node
        localparam int SRC = lvl_base(NL, l - 1) + 2 * i;
        localparam int DST = lvl_base(NL, l) + i;
        if (2 * i + 1 < lvl_nodes(NL, l - 1)) begin : g_pair
          ncm_add #(.PW(PW)) u_add (
            .clk(clk), .en(advance), .a(nd[SRC]), .b(nd[SRC+1]), .sum(nd[DST])
          );
        end else begin : g_pass
          ncm_add #(.PW(PW)) u_add (
            .clk(clk), .en(advance), .a(nd[SRC]), .b('0), .sum(nd[DST])
          );
        end
      end
    end
  endgenerate

  ncm_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk(clk), .rst_n(rst_n), .en(advance), .vin(in_valid), .vout(out_valid)
  );

  assign out_prod = nd[TOT-1];
endmodule

// File: rtl/naf_const_mult_chk.sv
module naf_const_mult_chk #(
  parameter int PW  = 48,
  parameter int LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_prod
);
  localparam int OW = $clog2(LAT + 1) + 2;
  logic [OW-1:0] occ;
  logic          take, give;
  assign take = in_valid && in_ready;
  assign give = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) occ <= '0;
    else occ <= occ + OW'(take) - OW'(give);

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= LAT);
  assert_emit_sourced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != '0);
  assert_block_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_free_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));
  assert_reset_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind naf_const_mult naf_const_mult_chk #(.PW(PW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
);

// File: tb/naf_const_mult_tb_top.sv
module naf_const_mult_tb_top;
  localparam int W  = 16;
  localparam int CW = 32;
  localparam int PW = W + CW;
  localparam logic [CW-1:0] K = 32'hE3A7_7B5D;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [PW-1:0] out_prod;

  always #(CLK_PERIOD/2) clk = ~clk;

  naf_const_mult #(.W(W), .CW(CW), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  typedef struct { logic [PW-1:0] p; int a; } item_t;
  item_t sb[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int lat_b = 1;
  bit lat_on = 1'b1;
  bit rnd_ready = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Driver: offers one operand, records the expected product at acceptance.
  task automatic send(logic [W-1:0] d, int gap);
    item_t it;
    bit acc;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = d;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
    end
    it.p = PW'(K) * PW'(d);
    it.a = cyc + 1;
    sb.push_back(it);
    if (gap > 0) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  task automatic drain();
    @(posedge clk); #1;
    in_valid = 1'b0;
    while (sb.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // Consumer side ready pattern.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // Monitor: pops the scoreboard on each handshake.
  initial begin
    bit stall_prev;
    logic [PW-1:0] held;
    item_t it;
    stall_prev = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (stall_prev)
          check(out_valid && (out_prod == held), "R4 stall hold", out_prod, held);
        if (out_valid && !out_ready)
          check(!in_ready, "R3 in_ready during stall", PW'(in_ready), '0);
        if (!out_valid)
          check(in_ready, "R3 in_ready when empty", PW'(in_ready), PW'(1));
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R6 unexpected product", out_prod, '0);
          end else begin
            it = sb.pop_front();
            check(out_prod == it.p, "R1 R6 product", out_prod, it.p);
            if (lat_on)
              check(cyc == it.a + lat_b - 1, "R2 latency", PW'(cyc), PW'(it.a + lat_b - 1));
          end
        end
        stall_prev = out_valid && !out_ready;
        held = out_prod;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    summary();
    $finish;
  end

  initial begin
    logic [CW+1:0] kk, x;
    int nz;
    kk = (CW+2)'(K);
    x  = ((kk * 3) ^ kk) >> 1;
    nz = $countones(x);
    lat_b = ((nz <= 1) ? 0 : $clog2(nz)) + 1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R5 out_valid in reset", PW'(out_valid), '0);
    check(in_ready, "R5 in_ready in reset", PW'(in_ready), PW'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R5 out_valid after reset", PW'(out_valid), '0);
    check(in_ready, "R5 in_ready after reset", PW'(in_ready), PW'(1));

    // Phase 1: consumer always ready, latency checked (R1, R2, R6).
    send('0, 0);
    send(W'(1), 0);
    send('1, 0);
    send({1'b1, {(W-1){1'b0}}}, 0);
    for (int i = 0; i < 150; i++) send(W'($urandom), 0);
    for (int i = 0; i < 60; i++) send(W'($urandom), $urandom_range(0, 3));
    send('1, 2);
    send('0, 0);
    drain();
    check(sb.size() == 0, "R6 all products returned", PW'(sb.size()), '0);

    // Phase 2: random back-pressure (R1, R3, R4, R6).
    lat_on = 1'b0;
    rnd_ready = 1'b1;
    for (int i = 0; i < 200; i++) send(W'($urandom), $urandom_range(0, 1));
    send('1, 0);
    send(W'(1), 0);
    rnd_ready = 1'b0;
    drain();
    check(sb.size() == 0, "R6 all products returned after stalls", PW'(sb.size()), '0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule